// File: doc/BRIEF.md
# Prefix-Extended Stack-Relative Byte Store Unit

This unit executes one kind of instruction: a 16-bit store that writes a single byte to memory at the stack pointer plus a displacement. The instruction itself holds only a 6-bit displacement. Up to two prefix words can come before it, and each adds 13 more bits, so the displacement can be 6, 19 or 32 bits wide. The unit counts the prefixes and keeps their immediates. When the store arrives, it builds the displacement, reads the source register, adds the stack pointer and issues a byte write on a 32-bit bus.

Instructions come in one word at a time with a valid strobe. A word is taken only while the unit is not busy. A prefix word is absorbed in a single cycle and does not raise busy. A store raises busy for two execute cycles. In the first cycle the unit reads the register file and the stack pointer. In the second cycle it presents the memory request, and it holds that request until the memory signals ready. One cycle later it pulses done.

Top module: `sprel_bstore`

## Requirements
- R1: A store word has bits 15:10 equal to 010101, an unsigned displacement in bits 9:4 and the source register index in bits 3:0. A word that is neither a store nor a prefix starts no memory request and discards any pending prefixes.
- R2: With no prefix pending, the store address is sp plus the zero-extended 6-bit field, modulo 2^32.
- R3: With one prefix pending, the displacement is {13'b0, prefix[12:0], imm6}, a 19-bit value zero-extended to 32 bits. For example, prefix 0x1 with field 0x1 gives sp + 0x41.
- R4: With two prefixes pending, the displacement is {first[12:0], second[12:0], imm6}, and the sum wraps modulo 2^32.
- R5: A third or later consecutive prefix discards the oldest kept chunk, so only the two most recent prefixes are used.
- R6: A prefix word has bits 15:13 equal to 110 and a 13-bit immediate in bits 12:0. It never raises busy. Pending prefixes are cleared when the unit accepts a store or any other non-prefix word.
- R7: The write data holds the low byte of the source register on byte lane addr[1:0], meaning bits 8*lane+7 down to 8*lane, with all other bits zero. The byte strobe is 1 shifted left by addr[1:0].
- R8: A word is accepted only on a cycle with instr_valid high and busy low. After a store is accepted, busy is high in the next cycle, which is execute cycle 1. In that cycle rf_addr equals the source index. mem_req rises in the following cycle, which is execute cycle 2.
- R9: mem_req, mem_addr, mem_wdata and mem_be stay stable from the cycle mem_req rises until the clock edge at which mem_ready is sampled high.
- R10: done is high for exactly one cycle, the cycle after the edge that completes the handshake. In that same cycle busy and mem_req are low.
- R11: During and right after reset, busy, mem_req and done are low and no prefix is pending.
- R12: Words offered while busy is high, whether prefix or store, have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | Instruction word valid |
| instr | input | 16 | Instruction word |
| sp | input | 32 | Current stack pointer, sampled in execute cycle 1 |
| rf_addr | output | 4 | Register file read index |
| rf_data | input | 32 | Register file read data, combinational from rf_addr |
| mem_req | output | 1 | Memory write request |
| mem_addr | output | 32 | Byte address of the write |
| mem_wdata | output | 32 | Write data with the byte on its lane |
| mem_be | output | 4 | One-hot byte strobe |
| mem_ready | input | 1 | Memory accepts the request |
| busy | output | 1 | Store in progress; new words are refused |
| done | output | 1 | One-cycle completion pulse |

## Verification
Faults in the prefix chunks or the prefix count are invisible until a store is issued. They then show up as a wrong mem_addr two cycles after that store is accepted, in the first cycle of mem_req. The chunk-order, saturation and wrap cases are chosen so that each kind of fault gives a different address. A wrong sequencer state shows up within one cycle, as a mem_req, busy or done that is missing or comes at the wrong time. Wrong lane arithmetic shows up in mem_be and mem_wdata in that same request cycle.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
  localparam int INSTR_W   = 16;
  localparam int XLEN      = 32;
  localparam int IMM_LO_W  = 6;
  localparam int PFX_W     = 13;
  localparam int PFX_DEPTH = 2;
  localparam int RIDX_W    = 4;
  localparam int LANES     = XLEN / 8;
  localparam int LANE_W    = $clog2(LANES);
  localparam int CNT_W     = $clog2(PFX_DEPTH + 1);

  localparam logic [5:0] STORE_OP = 6'b010101;
  localparam logic [2:0] PFX_OP   = 3'b110;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_EX1  = 2'd1,
    SEQ_EX2  = 2'd2
  } seq_state_e;

  // Displacement assembly: imm6 low, newest chunk next, older chunk on top.
  function automatic logic [XLEN-1:0] build_disp(
    input logic [CNT_W-1:0]    cnt,
    input logic [PFX_W-1:0]    newest,
    input logic [PFX_W-1:0]    older,
    input logic [IMM_LO_W-1:0] lo
  );
    logic [XLEN-1:0] d;
    d = XLEN'(lo);
    if (cnt >= CNT_W'(1)) d = d | (XLEN'(newest) << IMM_LO_W);
    if (cnt >= CNT_W'(2)) d = d | (XLEN'(older) << (IMM_LO_W + PFX_W));
    return d;
  endfunction

  function automatic logic [XLEN-1:0] place_byte(
    input logic [LANE_W-1:0] lane,
    input logic [7:0]        b
  );
    return XLEN'(b) << (8 * int'(lane));
  endfunction

  function automatic logic [LANES-1:0] lane_strobe(input logic [LANE_W-1:0] lane);
    return LANES'(1) << lane;
  endfunction
endpackage

// File: rtl/sbs_decode.sv
module sbs_decode
  import sbs_pkg::*;
(
  input  logic [INSTR_W-1:0]  instr,
  output logic                is_store,
  output logic                is_pfx,
  output logic [IMM_LO_W-1:0] imm_lo,
  output logic [RIDX_W-1:0]   src_idx,
  output logic [PFX_W-1:0]    pfx_chunk
);
  always_comb begin
    is_store  = (instr[INSTR_W-1 -: 6] == STORE_OP);
    is_pfx    = (instr[INSTR_W-1 -: 3] == PFX_OP);
    imm_lo    = instr[RIDX_W +: IMM_LO_W];
    src_idx   = instr[RIDX_W-1:0];
    pfx_chunk = instr[PFX_W-1:0];
  end
endmodule

// File: rtl/sbs_prefix_acc.sv
module sbs_prefix_acc #(
  parameter int CHUNK_W = 13,
  parameter int DEPTH   = 2,
  localparam int CW     = $clog2(DEPTH + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     push,
  input  logic                     clear,
  input  logic [CHUNK_W-1:0]       chunk_in,
  output logic [CW-1:0]            cnt,
  output logic [DEPTH*CHUNK_W-1:0] chunks
);
  logic [CHUNK_W-1:0] chunk_q [DEPTH];
  logic [CW-1:0]      cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clear) begin
      cnt_q <= '0;
    end else if (push && cnt_q != CW'(DEPTH)) begin
      cnt_q <= cnt_q + CW'(1);
    end
  end

  // Slot 0 holds the newest chunk; older chunks shift upward and fall off.
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        chunk_q[i] <= '0;
      end else if (push) begin
        if (i == 0) chunk_q[i] <= chunk_in;
        else        chunk_q[i] <= chunk_q[(i > 0) ? i-1 : 0];
      end
    end
    assign chunks[i*CHUNK_W +: CHUNK_W] = chunk_q[i];
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/sbs_store_seq.sv
module sbs_store_seq
  import sbs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [XLEN-1:0]   disp_in,
  input  logic [RIDX_W-1:0] src_in,
  input  logic [XLEN-1:0]   sp,
  input  logic [XLEN-1:0]   rf_data,
  input  logic              mem_ready,
  output logic [RIDX_W-1:0] rf_addr,
  output logic              busy,
  output logic              mem_req,
  output logic [XLEN-1:0]   mem_addr,
  output logic [XLEN-1:0]   mem_wdata,
  output logic [LANES-1:0]  mem_be,
  output logic              done,
  output logic              ex1_evt,
  output logic              handoff_evt
);
  seq_state_e        st_q, st_n;
  logic [XLEN-1:0]   disp_q;
  logic [RIDX_W-1:0] src_q;
  logic [XLEN-1:0]   addr_q, wdata_q;
  logic [LANES-1:0]  be_q;
  logic              done_q;
  logic [XLEN-1:0]   addr_n;

  assign ex1_evt     = (st_q == SEQ_EX1);
  assign handoff_evt = (st_q == SEQ_EX2) && mem_ready;
  assign addr_n      = sp + disp_q;

  always_comb begin
    st_n = st_q;
    unique case (st_q)
      SEQ_IDLE: if (start) st_n = SEQ_EX1;
      SEQ_EX1:  st_n = SEQ_EX2;
      SEQ_EX2:  if (mem_ready) st_n = SEQ_IDLE;
      default:  st_n = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= SEQ_IDLE;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_n;
      done_q <= handoff_evt;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      disp_q  <= '0;
      src_q   <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      be_q    <= '0;
    end else begin
      if (start && st_q == SEQ_IDLE) begin
        disp_q <= disp_in;
        src_q  <= src_in;
      end
      if (ex1_evt) begin
        addr_q  <= addr_n;
        wdata_q <= place_byte(addr_n[LANE_W-1:0], rf_data[7:0]);
        be_q    <= lane_strobe(addr_n[LANE_W-1:0]);
      end
    end
  end

  assign rf_addr   = src_q;
  assign busy      = (st_q != SEQ_IDLE);
  assign mem_req   = (st_q == SEQ_EX2);
  assign mem_addr  = addr_q;
  assign mem_wdata = wdata_q;
  assign mem_be    = be_q;
  assign done      = done_q;
endmodule

// File: rtl/sprel_bstore.sv
module sprel_bstore
  import sbs_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        instr_valid,
  input  logic [15:0] instr,
  input  logic [31:0] sp,
  output logic [3:0]  rf_addr,
  input  logic [31:0] rf_data,
  output logic        mem_req,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  output logic [3:0]  mem_be,
  input  logic        mem_ready,
  output logic        busy,
  output logic        done
);
  logic                     is_store, is_pfx;
  logic [IMM_LO_W-1:0]      imm_lo;
  logic [RIDX_W-1:0]        src_idx;
  logic [PFX_W-1:0]         pfx_chunk;
  logic [CNT_W-1:0]         pfx_cnt;
  logic [PFX_DEPTH*PFX_W-1:0] pfx_chunks;
  logic                     take_word;
  logic                     accept_evt;
  logic                     push_evt;
  logic                     drop_evt;
  logic [XLEN-1:0]          disp;
  logic                     ex1_evt, handoff_evt;

  sbs_decode u_dec (
    .instr     (instr),
    .is_store  (is_store),
    .is_pfx    (is_pfx),
    .imm_lo    (imm_lo),
    .src_idx   (src_idx),
    .pfx_chunk (pfx_chunk)
  );

  assign take_word  = instr_valid && !busy;
  assign accept_evt = take_word && is_store;
  assign push_evt   = take_word && is_pfx;
  assign drop_evt   = take_word && !is_pfx;

  sbs_prefix_acc #(.CHUNK_W(PFX_W), .DEPTH(PFX_DEPTH)) u_pfx (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (push_evt),
    .clear    (drop_evt),
    .chunk_in (pfx_chunk),
    .cnt      (pfx_cnt),
    .chunks   (pfx_chunks)
  );

  assign disp = build_disp(pfx_cnt, pfx_chunks[0 +: PFX_W], pfx_chunks[PFX_W +: PFX_W], imm_lo);

  sbs_store_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (accept_evt),
    .disp_in     (disp),
    .src_in      (src_idx),
    .sp          (sp),
    .rf_data     (rf_data),
    .mem_ready   (mem_ready),
    .rf_addr     (rf_addr),
    .busy        (busy),
    .mem_req     (mem_req),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata),
    .mem_be      (mem_be),
    .done        (done),
    .ex1_evt     (ex1_evt),
    .handoff_evt (handoff_evt)
  );
endmodule

// File: rtl/sprel_bstore_chk.sv
module sprel_bstore_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        mem_req,
  input logic        mem_ready,
  input logic [31:0] mem_addr,
  input logic [31:0] mem_wdata,
  input logic [3:0]  mem_be,
  input logic        done,
  input logic        accept_evt,
  input logic        ex1_evt,
  input logic [1:0]  pfx_cnt
);
  assert_accept_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    accept_evt |=> busy && ex1_evt);

  assert_req_second_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ex1_evt |=> mem_req);

  assert_hold_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> mem_req && $stable(mem_addr) && $stable(mem_wdata) && $stable(mem_be));

  assert_strobe_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> $countones(mem_be) == 1);

  assert_lane_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_wdata & ~{{8{mem_be[3]}}, {8{mem_be[2]}}, {8{mem_be[1]}}, {8{mem_be[0]}}}) == 32'h0);

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_after_handshake_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> !busy && !mem_req && $past(mem_req && mem_ready));

  assert_prefix_depth_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pfx_cnt <= 2'd2);

  assert_no_accept_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !accept_evt);
endmodule

bind sprel_bstore sprel_bstore_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (busy),
  .mem_req    (mem_req),
  .mem_ready  (mem_ready),
  .mem_addr   (mem_addr),
  .mem_wdata  (mem_wdata),
  .mem_be     (mem_be),
  .done       (done),
  .accept_evt (accept_evt),
  .ex1_evt    (ex1_evt),
  .pfx_cnt    (pfx_cnt)
);

// File: tb/sprel_bstore_bench.sv
module sprel_bstore_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        instr_valid = 1'b0;
  logic [15:0] instr = 16'h0;
  logic [31:0] sp = 32'h0;
  logic [3:0]  rf_addr;
  logic [31:0] rf_data;
  logic        mem_req;
  logic [31:0] mem_addr, mem_wdata;
  logic [3:0]  mem_be;
  logic        mem_ready = 1'b0;
  logic        busy, done;

  logic [31:0] rf [16];
  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #10 clk = ~clk;  // 50 MHz

  assign rf_data = rf[rf_addr];

  sprel_bstore u_sprel_bstore (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr), .sp(sp),
    .rf_addr(rf_addr), .rf_data(rf_data), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_be(mem_be), .mem_ready(mem_ready), .busy(busy), .done(done)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int          m_phase;
  int unsigned m_pfx[$];
  longint      m_disp;
  int          m_src;
  logic [31:0] m_addr, m_data;
  logic [3:0]  m_be;
  bit          m_done;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase = 0; m_pfx.delete(); m_done = 0;
      m_addr = 0; m_data = 0; m_be = 0;
    end else begin
      m_done = 0;
      case (m_phase)
        0: if (instr_valid) begin
          if (instr[15:13] == 3'b110) begin
            m_pfx.push_back(int'(instr[12:0]));
            if (m_pfx.size() > 2) void'(m_pfx.pop_front());
          end else if (instr[15:10] == 6'b010101) begin
            m_disp = longint'(instr[9:4]);
            for (int k = 0; k < m_pfx.size(); k++)
              m_disp = m_disp + (longint'(m_pfx[m_pfx.size()-1-k]) << (6 + 13*k));
            m_src = int'(instr[3:0]);
            m_pfx.delete();
            m_phase = 1;
          end else begin
            m_pfx.delete();
          end
        end
        1: begin
          m_addr = 32'((longint'(sp) + m_disp) % 64'h1_0000_0000);
          m_be = 4'b0001 << (m_addr % 4);
          m_data = 32'(rf[m_src][7:0]) << (8 * (m_addr % 4));
          m_phase = 2;
        end
        default: if (mem_ready) begin m_phase = 0; m_done = 1; end
      endcase
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R8 busy", 32'(busy), 32'(m_phase != 0));
      chk("R9 mem_req", 32'(mem_req), 32'(m_phase == 2));
      chk("R10 done", 32'(done), 32'(m_done));
      if (m_phase == 1) chk("R8 rf_addr", 32'(rf_addr), 32'(m_src));
      if (m_phase == 2) begin
        chk("R2 mem_addr", mem_addr, m_addr);
        chk("R7 mem_wdata", mem_wdata, m_data);
        chk("R7 mem_be", 32'(mem_be), 32'(m_be));
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  function automatic logic [15:0] st_w(input int imm, input int src);
    return {6'b010101, 6'(imm), 4'(src)};
  endfunction
  function automatic logic [15:0] pf_w(input int v);
    return {3'b110, 13'(v)};
  endfunction

  task automatic issue(input logic [15:0] w);
    @(negedge clk); instr_valid = 1'b1; instr = w;
    @(negedge clk); instr_valid = 1'b0; instr = 16'h0;
  endtask

  task automatic do_store(input logic [15:0] w, input int stall, output logic [31:0] a);
    issue(w);
    while (!mem_req) @(negedge clk);
    a = mem_addr;
    repeat (stall) @(negedge clk);
    mem_ready = 1'b1;
    @(negedge clk);
    mem_ready = 1'b0;
    chk("R10 done after handshake", 32'(done), 32'd1);
    chk("R10 busy low with done", 32'(busy), 32'd0);
  endtask

  logic [31:0] got;
  logic [31:0] seed = 32'h1234_5679;
  function automatic logic [31:0] nxt(input logic [31:0] s);
    logic [31:0] x = s;
    x = x ^ (x << 13); x = x ^ (x >> 17); x = x ^ (x << 5);
    return x;
  endfunction

  initial begin
    for (int i = 0; i < 16; i++) rf[i] = {8'(i), 8'(i*3), 8'(i*5), 8'(8'h30 + i)};

    repeat (3) begin
      @(negedge clk);
      chk("R11 busy in reset", 32'(busy), 32'd0);
      chk("R11 mem_req in reset", 32'(mem_req), 32'd0);
      chk("R11 done in reset", 32'(done), 32'd0);
    end
    rst_n = 1'b1;

    sp = 32'h0000_1000;
    do_store(st_w(6'h2A, 3), 0, got);
    chk("R2 no prefix", got, 32'h0000_102A);

    issue(pf_w(1));
    chk("R6 prefix not busy", 32'(busy), 32'd0);
    do_store(st_w(1, 0), 2, got);
    chk("R3 single prefix 0x41", got, 32'h0000_1041);

    issue(pf_w(13'h1FFF));
    do_store(st_w(6'h3F, 5), 0, got);
    chk("R3 zero-extended 19-bit", got, 32'h0008_0FFF);

    issue(pf_w(2)); issue(pf_w(3));
    do_store(st_w(5, 7), 1, got);
    chk("R4 two prefixes", got, 32'h0010_10C5);

    sp = 32'hFFFF_FF00;
    issue(pf_w(13'h1FFF)); issue(pf_w(13'h1FFF));
    do_store(st_w(6'h3F, 9), 0, got);
    chk("R4 wrap", got, 32'hFFFF_FEFF);

    sp = 32'h0;
    issue(pf_w(13'h0AAA)); issue(pf_w(1)); issue(pf_w(2));
    do_store(st_w(0, 2), 0, got);
    chk("R5 oldest dropped", got, 32'h0008_0080);

    sp = 32'h0000_2000;
    issue(pf_w(13'h0155)); issue(16'h0000);
    chk("R1 other word no request", 32'(busy), 32'd0);
    do_store(st_w(4, 1), 0, got);
    chk("R1 other word clears prefix", got, 32'h0000_2004);

    // words offered while busy must be ignored
    @(negedge clk); instr_valid = 1'b1; instr = st_w(3, 4);
    @(negedge clk); instr = pf_w(13'h1FFF);
    @(negedge clk); instr = st_w(9, 4);
    @(negedge clk); instr_valid = 1'b0; instr = 16'h0; mem_ready = 1'b1;
    @(negedge clk); mem_ready = 1'b0;
    chk("R12 busy store ends", 32'(busy), 32'd0);
    @(negedge clk);
    chk("R12 no second request", 32'(mem_req), 32'd0);
    do_store(st_w(7, 6), 0, got);
    chk("R12 busy prefix ignored", got, 32'h0000_2007);

    for (int it = 0; it < 60; it++) begin
      seed = nxt(seed);
      sp = nxt(seed ^ 32'hA5A5_0F0F);
      for (int p = 0; p < int'(seed[1:0]); p++) begin
        seed = nxt(seed);
        issue(pf_w(int'(seed[12:0])));
      end
      seed = nxt(seed);
      do_store(st_w(int'(seed[9:4]), int'(seed[3:0])), int'(seed[17:16]) % 3, got);
    end

    repeat (3) @(negedge clk);
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R8 watchdog actual=hung expected=completion");
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule